// File: doc/BRIEF.md
# Interrupt Router Register Window

This block is the programming front end of a 24-input interrupt router. Software sees only two memory-mapped words: an 8-bit select word and a 32-bit data window. Each window access reaches whichever internal register the select word currently names. Those registers are an identification register, a read-only version register, an arbitration-ID register that mirrors the identification value, and a 64-bit routing entry for each input pin. Each routing entry is reached as two 32-bit halves.

Every routing entry is driven out field by field to the delivery logic. The delivery logic owns two status bits in each entry, remote request and busy, and updates them through set and clear strobes. Software writes merge into an entry half by half and never change those two bits. There is one exception: an entry left in edge mode after a write loses its remote request. Two one-cycle events are produced for downstream logic. One reports any write to an entry. The other reports a change of an entry's mask bit.

Accesses arrive on a valid/ready request channel. Reads return data on a valid/ready response channel. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is low only while a read response is pending and `rsp_ready` is low. This holds back writes as well as reads.

Top module: `intr_route_regwin`

## Requirements
- R1: A write to offset 0x00 stores the low 8 bits of the data as the select value. A read of offset 0x00 returns that value zero-extended.
- R2: With select 0x01 the window reads (pin count − 1) in bits 23:16 and the version code 0x11 in bits 7:0, with zeros elsewhere. For 24 pins this is 0x00170011. Writes to it change nothing.
- R3: With select 0x00 a window write stores data bits 27:24 as a 4-bit ID, and a read returns it in bits 27:24 with all other bits zero. Select 0x02 reads the same value, and a write with select 0x02 is ignored.
- R4: A select of 0x10 or more addresses entry (select − 0x10) >> 1. Select bit 0 = 1 picks entry bits 63:32, and 0 picks bits 31:0. The entry layout is vector 7:0, delivery mode 10:8, destination mode 11, busy 12, polarity 13, remote request 14, trigger 15 (1 = level), mask 16, destination 63:56. Each field appears on the matching per-pin output.
- R5: A window read returns 0xFFFFFFFF for select values 0x03 to 0x0F and for any entry index of 24 or more. Window writes to those selects change no state and raise no event.
- R6: A window write to an entry leaves its busy bit (12) and remote-request bit (14) as they were, whatever the data holds.
- R7: After any write to an entry, if its trigger bit (15) is 0 the remote-request bit is 0 in the next cycle. This holds even if a remote-set strobe arrives in the same cycle.
- R8: A window write that flips an entry's mask bit raises `mask_evt_valid` for exactly one cycle, in the cycle after acceptance, with the pin index and the new mask value. Every accepted entry write raises `cfg_evt_valid` for one cycle with the pin index.
- R9: After reset every entry reads 0x00010000 in its low half and 0 in its high half, so every mask bit is set. The select value and the ID are 0.
- R10: Reads of any offset other than 0x00 and 0x10 return 0, and writes to those offsets are ignored.
- R11: A read response stays valid with stable data until `rsp_ready` is high. While it waits, `req_ready` is low.
- R12: The remote-set and busy-set strobes set their bit in the next cycle, and the clear strobes clear it (a clear wins over a set). A strobe arriving in the same cycle as a software write to that entry still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request accepted when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Word offset: 0x00 select, 0x10 window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Read data taken when high |
| rsp_rdata | output | 32 | Read data |
| remote_set | input | 24 | Per-pin remote-request set strobe |
| remote_clr | input | 24 | Per-pin remote-request clear strobe |
| busy_set | input | 24 | Per-pin busy set strobe |
| busy_clr | input | 24 | Per-pin busy clear strobe |
| pin_vector | output | 192 | Per-pin vector, 8 bits per pin |
| pin_dlv_mode | output | 72 | Per-pin delivery mode, 3 bits per pin |
| pin_dst_logical | output | 24 | Per-pin destination mode |
| pin_busy | output | 24 | Per-pin busy bit |
| pin_active_low | output | 24 | Per-pin polarity |
| pin_remote | output | 24 | Per-pin remote request |
| pin_level | output | 24 | Per-pin trigger mode, 1 = level |
| pin_mask | output | 24 | Per-pin mask |
| pin_dest | output | 192 | Per-pin destination, 8 bits per pin |
| mask_evt_valid | output | 1 | Mask-changed pulse |
| mask_evt_pin | output | 5 | Pin whose mask changed |
| mask_evt_value | output | 1 | New mask value |
| cfg_evt_valid | output | 1 | Entry-written pulse |
| cfg_evt_pin | output | 5 | Pin whose entry was written |

## Verification
A software write to an entry and a hardware strobe to the same entry's status bits can land in the same clock edge. The bench provokes this by driving a remote-set strobe in the cycle a window write is accepted. It does so once with a level-mode value and once with an edge-mode value. It then reads the entry back through the window and expects the remote bit set in the first case and cleared in the second. The same readback shows the busy bit untouched, and the event outputs are observed in the cycle after acceptance to confirm the mask pulse fires only when the mask really changes.

// File: rtl/irw_pkg.sv
package irw_pkg;

  localparam int ENT_W    = 64;
  localparam int B_BUSY   = 12;
  localparam int B_REMOTE = 14;
  localparam int B_LEVEL  = 15;
  localparam int B_MASK   = 16;
  localparam logic [ENT_W-1:0] ENT_RESET = 64'h0000_0000_0001_0000;

  localparam logic [7:0] OFF_SELECT = 8'h00;
  localparam logic [7:0] OFF_WINDOW = 8'h10;
  localparam logic [7:0] SEL_ENTRY0 = 8'h10;

  typedef enum logic [2:0] {
    SK_ID,
    SK_VER,
    SK_ARB,
    SK_ENT,
    SK_NONE
  } sel_kind_e;

endpackage

// File: rtl/irw_sel_decode.sv
module irw_sel_decode
  import irw_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int IW    = $clog2(NPINS)
) (
  input  logic [7:0]    sel,
  output sel_kind_e     kind,
  output logic [IW-1:0] idx,
  output logic          upper
);

  logic [7:0] rel;

  assign rel   = (sel - SEL_ENTRY0) >> 1;
  assign upper = sel[0];

  always_comb begin
    idx  = '0;
    kind = SK_NONE;
    case (sel)
      8'h00:   kind = SK_ID;
      8'h01:   kind = SK_VER;
      8'h02:   kind = SK_ARB;
      default: begin
        if (sel >= SEL_ENTRY0 && int'(rel) < NPINS) begin
          kind = SK_ENT;
          idx  = rel[IW-1:0];
        end
      end
    endcase
  end

endmodule

// File: rtl/irw_entry_slot.sv
module irw_entry_slot
  import irw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      wdata,
  input  logic             remote_set,
  input  logic             remote_clr,
  input  logic             busy_set,
  input  logic             busy_clr,
  output logic [ENT_W-1:0] entry_q,
  output logic             mask_toggle
);

  logic [ENT_W-1:0] nxt;
  logic             wr_any;

  assign wr_any      = wr_lo | wr_hi;
  assign mask_toggle = wr_lo && (wdata[B_MASK] != entry_q[B_MASK]);

  always_comb begin
    nxt = entry_q;
    if (wr_lo) nxt[31:0]  = wdata;
    if (wr_hi) nxt[63:32] = wdata;
    // status bits belong to the delivery side: restore, then apply strobes
    nxt[B_BUSY]   = (entry_q[B_BUSY] | busy_set) & ~busy_clr;
    nxt[B_REMOTE] = (entry_q[B_REMOTE] | remote_set) & ~remote_clr;
    if (wr_any && !nxt[B_LEVEL]) nxt[B_REMOTE] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) entry_q <= ENT_RESET;
    else        entry_q <= nxt;
  end

  p_busy_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !busy_set && !busy_clr) |=> (entry_q[B_BUSY] == $past(entry_q[B_BUSY])));

  p_edge_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> (entry_q[B_LEVEL] || !entry_q[B_REMOTE]));

  p_remote_hw_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (remote_set && !remote_clr && !(wr_any && !nxt[B_LEVEL])) |=> entry_q[B_REMOTE]);

endmodule

// File: rtl/irw_read_mux.sv
module irw_read_mux
  import irw_pkg::*;
#(
  parameter int         NPINS    = 24,
  parameter logic [7:0] VER_CODE = 8'h11,
  parameter int         IW       = $clog2(NPINS)
) (
  input  sel_kind_e                   kind,
  input  logic [IW-1:0]               idx,
  input  logic                        upper,
  input  logic [3:0]                  id_q,
  input  logic [NPINS-1:0][ENT_W-1:0] ent,
  output logic [31:0]                 data
);

  localparam logic [7:0] MAX_PIN = 8'(NPINS - 1);

  always_comb begin
    case (kind)
      SK_ID,
      SK_ARB:  data = {4'h0, id_q, 24'h0};
      SK_VER:  data = {8'h00, MAX_PIN, 8'h00, VER_CODE};
      SK_ENT:  data = upper ? ent[idx][63:32] : ent[idx][31:0];
      default: data = '1;
    endcase
  end

endmodule

// File: rtl/intr_route_regwin.sv
module intr_route_regwin
  import irw_pkg::*;
#(
  parameter int         NPINS    = 24,
  parameter logic [7:0] VER_CODE = 8'h11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [7:0]                 req_offset,
  input  logic [31:0]                req_wdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [31:0]                rsp_rdata,
  input  logic [NPINS-1:0]           remote_set,
  input  logic [NPINS-1:0]           remote_clr,
  input  logic [NPINS-1:0]           busy_set,
  input  logic [NPINS-1:0]           busy_clr,
  output logic [NPINS*8-1:0]         pin_vector,
  output logic [NPINS*3-1:0]         pin_dlv_mode,
  output logic [NPINS-1:0]           pin_dst_logical,
  output logic [NPINS-1:0]           pin_busy,
  output logic [NPINS-1:0]           pin_active_low,
  output logic [NPINS-1:0]           pin_remote,
  output logic [NPINS-1:0]           pin_level,
  output logic [NPINS-1:0]           pin_mask,
  output logic [NPINS*8-1:0]         pin_dest,
  output logic                       mask_evt_valid,
  output logic [$clog2(NPINS)-1:0]   mask_evt_pin,
  output logic                       mask_evt_value,
  output logic                       cfg_evt_valid,
  output logic [$clog2(NPINS)-1:0]   cfg_evt_pin
);

  localparam int IW = $clog2(NPINS);

  logic [7:0]                  sel_q;
  logic [3:0]                  id_q;
  logic [NPINS-1:0][ENT_W-1:0] ent;
  logic [NPINS-1:0]            wr_lo, wr_hi, mtog;
  sel_kind_e                   dec_kind;
  logic [IW-1:0]               dec_idx;
  logic                        dec_upper;
  logic [31:0]                 win_rdata, rd_data;
  logic                        acc, win_wr, ent_wr;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign win_wr    = acc && req_write && (req_offset == OFF_WINDOW);
  assign ent_wr    = win_wr && (dec_kind == SK_ENT);

  irw_sel_decode #(.NPINS(NPINS), .IW(IW)) u_dec (
    .sel   (sel_q),
    .kind  (dec_kind),
    .idx   (dec_idx),
    .upper (dec_upper)
  );

  irw_read_mux #(.NPINS(NPINS), .VER_CODE(VER_CODE), .IW(IW)) u_rmux (
    .kind  (dec_kind),
    .idx   (dec_idx),
    .upper (dec_upper),
    .id_q  (id_q),
    .ent   (ent),
    .data  (win_rdata)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign wr_lo[g] = ent_wr && (dec_idx == IW'(g)) && !dec_upper;
    assign wr_hi[g] = ent_wr && (dec_idx == IW'(g)) &&  dec_upper;

    irw_entry_slot u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_lo       (wr_lo[g]),
      .wr_hi       (wr_hi[g]),
      .wdata       (req_wdata),
      .remote_set  (remote_set[g]),
      .remote_clr  (remote_clr[g]),
      .busy_set    (busy_set[g]),
      .busy_clr    (busy_clr[g]),
      .entry_q     (ent[g]),
      .mask_toggle (mtog[g])
    );

    assign pin_vector[g*8 +: 8]   = ent[g][7:0];
    assign pin_dlv_mode[g*3 +: 3] = ent[g][10:8];
    assign pin_dst_logical[g]     = ent[g][11];
    assign pin_busy[g]            = ent[g][B_BUSY];
    assign pin_active_low[g]      = ent[g][13];
    assign pin_remote[g]          = ent[g][B_REMOTE];
    assign pin_level[g]           = ent[g][B_LEVEL];
    assign pin_mask[g]            = ent[g][B_MASK];
    assign pin_dest[g*8 +: 8]     = ent[g][63:56];
  end

  always_comb begin
    case (req_offset)
      OFF_SELECT: rd_data = {24'h0, sel_q};
      OFF_WINDOW: rd_data = win_rdata;
      default:    rd_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else if (acc && req_write) begin
      if (req_offset == OFF_SELECT) sel_q <= req_wdata[7:0];
      if (win_wr && dec_kind == SK_ID) id_q <= req_wdata[27:24];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_evt_valid <= 1'b0;
      mask_evt_pin   <= '0;
      mask_evt_value <= 1'b0;
      cfg_evt_valid  <= 1'b0;
      cfg_evt_pin    <= '0;
    end else begin
      mask_evt_valid <= |mtog;
      mask_evt_pin   <= dec_idx;
      mask_evt_value <= req_wdata[B_MASK];
      cfg_evt_valid  <= ent_wr;
      cfg_evt_pin    <= dec_idx;
    end
  end

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_evt_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt_valid |-> (pin_mask[mask_evt_pin] == mask_evt_value));

  p_evt_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt_valid |-> (cfg_evt_valid && cfg_evt_pin == mask_evt_pin));

endmodule

// File: tb/intr_route_regwin_test.sv
module intr_route_regwin_test;

  localparam int NP = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0]  req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic [NP-1:0] remote_set = '0, remote_clr = '0, busy_set = '0, busy_clr = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NP*8-1:0] pin_vector, pin_dest;
  logic [NP*3-1:0] pin_dlv_mode;
  logic [NP-1:0] pin_dst_logical, pin_busy, pin_active_low, pin_remote, pin_level, pin_mask;
  logic mask_evt_valid, mask_evt_value, cfg_evt_valid;
  logic [4:0] mask_evt_pin, cfg_evt_pin;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  intr_route_regwin uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_offset(req_offset), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .remote_set(remote_set), .remote_clr(remote_clr),
    .busy_set(busy_set), .busy_clr(busy_clr),
    .pin_vector(pin_vector), .pin_dlv_mode(pin_dlv_mode),
    .pin_dst_logical(pin_dst_logical), .pin_busy(pin_busy),
    .pin_active_low(pin_active_low), .pin_remote(pin_remote),
    .pin_level(pin_level), .pin_mask(pin_mask), .pin_dest(pin_dest),
    .mask_evt_valid(mask_evt_valid), .mask_evt_pin(mask_evt_pin),
    .mask_evt_value(mask_evt_value), .cfg_evt_valid(cfg_evt_valid),
    .cfg_evt_pin(cfg_evt_pin)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d, input logic [NP-1:0] rs);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_offset = off; req_wdata = d; remote_set = rs;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; remote_set = '0;
  endtask

  task automatic rd(input logic [7:0] off, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_offset = off;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic rd_win(input logic [7:0] s, output logic [31:0] d);
    wr(8'h00, {24'h0, s}, '0);
    rd(8'h10, d);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R9 mask outputs", {8'h0, pin_mask}, {8'h0, {NP{1'b1}}});
    rd(8'h00, d);        chk("R9 select", d, 32'h0);
    rd(8'h10, d);        chk("R9 id", d, 32'h0);
    rd_win(8'h10, d);    chk("R9 entry0 low", d, 32'h0001_0000);
    rd_win(8'h3F, d);    chk("R9 entry23 high", d, 32'h0);
  endtask

  task automatic t_select;
    logic [31:0] d;
    wr(8'h00, 32'h1234_56A5, '0);
    rd(8'h00, d);        chk("R1 select low byte", d, 32'h0000_00A5);
  endtask

  task automatic t_version;
    logic [31:0] d;
    rd_win(8'h01, d);    chk("R2 version", d, 32'h0017_0011);
    wr(8'h10, 32'hFFFF_FFFF, '0);
    rd(8'h10, d);        chk("R2 version after write", d, 32'h0017_0011);
  endtask

  task automatic t_id;
    logic [31:0] d;
    wr(8'h00, 32'h0, '0);
    wr(8'h10, 32'hFF00_0000, '0);
    rd(8'h10, d);        chk("R3 id", d, 32'h0F00_0000);
    rd_win(8'h02, d);    chk("R3 arb mirror", d, 32'h0F00_0000);
    wr(8'h10, 32'h3000_0000, '0);
    rd_win(8'h00, d);    chk("R3 arb write ignored", d, 32'h0F00_0000);
  endtask

  task automatic t_entry;
    logic [31:0] d;
    wr(8'h00, 32'h1A, '0);
    wr(8'h10, 32'h0000_8031, '0);
    chk("R8 mask evt valid", {31'h0, mask_evt_valid}, 32'h1);
    chk("R8 mask evt pin", {27'h0, mask_evt_pin}, 32'd5);
    chk("R8 mask evt value", {31'h0, mask_evt_value}, 32'h0);
    chk("R8 cfg evt", {26'h0, cfg_evt_valid, cfg_evt_pin}, {26'h0, 1'b1, 5'd5});
    @(negedge clk);
    chk("R8 single-cycle pulse", {30'h0, mask_evt_valid, cfg_evt_valid}, 32'h0);
    wr(8'h00, 32'h1B, '0);
    wr(8'h10, 32'hAB00_0000, '0);
    chk("R8 no mask evt on upper", {31'h0, mask_evt_valid}, 32'h0);
    rd_win(8'h1A, d);    chk("R4 entry5 low", d, 32'h0000_8031);
    rd_win(8'h1B, d);    chk("R4 entry5 high", d, 32'hAB00_0000);
    chk("R4 field outputs", {8'h0, pin_dest[5*8 +: 8], pin_vector[5*8 +: 8], 6'h0, pin_level[5], pin_mask[5]},
        {8'h0, 8'hAB, 8'h31, 6'h0, 1'b1, 1'b0});
    wr(8'h00, 32'h1A, '0);
    wr(8'h10, 32'h0000_D031, '0);
    rd(8'h10, d);        chk("R6 status bits not writable", d, 32'h0000_8031);
  endtask

  task automatic t_hw;
    logic [31:0] d;
    @(negedge clk);
    remote_set[5] = 1'b1; busy_set[5] = 1'b1;
    @(negedge clk);
    remote_set = '0; busy_set = '0;
    chk("R12 hw strobes", {30'h0, pin_remote[5], pin_busy[5]}, 32'h3);
    wr(8'h10, 32'h0000_8032, '0);
    chk("R8 cfg evt without mask change", {30'h0, cfg_evt_valid, mask_evt_valid}, 32'h2);
    rd(8'h10, d);        chk("R6 status preserved", d, 32'h0000_D032);
    wr(8'h10, 32'h0000_0032, '0);
    rd(8'h10, d);        chk("R7 edge clears remote", d, 32'h0000_1032);
    @(negedge clk);
    remote_set[5] = 1'b1; remote_clr[5] = 1'b1; busy_clr[5] = 1'b1;
    @(negedge clk);
    remote_set = '0; remote_clr = '0; busy_clr = '0;
    chk("R12 clear wins", {30'h0, pin_remote[5], pin_busy[5]}, 32'h0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    logic [NP-1:0] rs;
    rs = '0; rs[7] = 1'b1;
    wr(8'h00, 32'h1E, '0);
    wr(8'h10, 32'h0001_8040, rs);
    rd(8'h10, d);        chk("R12 set with level write", d, 32'h0001_C040);
    wr(8'h10, 32'h0001_0040, rs);
    rd(8'h10, d);        chk("R7 edge write beats set", d, 32'h0001_0040);
  endtask

  task automatic t_oob;
    logic [31:0] d;
    rd_win(8'h40, d);    chk("R5 index 24 reads ones", d, 32'hFFFF_FFFF);
    rd_win(8'h05, d);    chk("R5 gap select reads ones", d, 32'hFFFF_FFFF);
    rd_win(8'hFF, d);    chk("R5 top select reads ones", d, 32'hFFFF_FFFF);
    wr(8'h00, 32'h40, '0);
    wr(8'h10, 32'h0, '0);
    chk("R5 no event on oob write", {30'h0, cfg_evt_valid, mask_evt_valid}, 32'h0);
    chk("R5 masks untouched", {8'h0, pin_mask}, {8'h0, {NP{1'b1}} & ~(24'h1 << 5)});
    rd_win(8'h3E, d);    chk("R5 entry23 unchanged", d, 32'h0001_0000);
  endtask

  task automatic t_other_off;
    logic [31:0] d;
    wr(8'h00, 32'h11, '0);
    wr(8'h20, 32'h0000_00FF, '0);
    rd(8'h00, d);        chk("R10 select unchanged", d, 32'h0000_0011);
    rd(8'h20, d);        chk("R10 offset 0x20 reads zero", d, 32'h0);
    rd(8'h04, d);        chk("R10 offset 0x04 reads zero", d, 32'h0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_offset = 8'h00;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 response valid", {31'h0, rsp_valid}, 32'h1);
    chk("R11 response data", rsp_rdata, 32'h0000_0011);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 held", {30'h0, rsp_valid, req_ready}, 32'h2);
      chk("R11 data stable", rsp_rdata, 32'h0000_0011);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 released", {30'h0, rsp_valid, req_ready}, 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_select();
    t_version();
    t_id();
    t_entry();
    t_hw();
    t_same_cycle();
    t_oob();
    t_other_off();
    t_backpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule